// File: doc/BRIEF.md
# Dual-Mode Ethernet Receive Byte Assembler

This block sits between the 4-bit receive data bus of an Ethernet PHY and the receive path of a MAC. It runs entirely on the PHY's receive clock and turns the nibble bus plus its data-valid line into a byte stream. Each byte carries a valid strobe and start-of-frame and end-of-frame flags. The preamble and the start-of-frame delimiter are found and stripped, so the first byte delivered is the first destination-address byte.

A speed-mode input tells the block how the bus is sampled. In gigabit mode, the rising edge of the receive clock carries the low nibble of a byte and the falling edge carries the high nibble, so one byte arrives per clock. In 10/100 mode, only the rising edge carries data, at 25 MHz for 100 Mb/s, and two consecutive nibbles form a byte with the low nibble first. The mode is never guessed from the line. It is set from outside after the negotiated link speed has been read from the PHY. A wrong setting is not repaired: it shows up as misaligned or missing bytes.

Top module: `rgmii_rx_assembler`

## Requirements
- R1: While reset is asserted and afterwards until a delimiter has been accepted, out_valid, out_sof, out_eof and align_err are 0. A reset in the middle of a frame drops the rest of that frame, even if rx_dv stays high.
- R2: With gig_mode=1, each received byte equals {nibble sampled on the falling edge, nibble sampled on the preceding rising edge}, and the output carries one byte per clock while the frame lasts.
- R3: With gig_mode=0, only rising-edge samples are used. After the delimiter, the first nibble is bits [3:0] of a byte and the second nibble is bits [7:4].
- R4: Preamble and delimiter are never output. In gigabit mode the preamble symbol is byte 0x55 and the delimiter is byte 0xD5. In 10/100 mode the preamble symbol is nibble 0x5 and the delimiter is nibble 0xD. At least one preamble symbol must come before the delimiter, and a preamble shorter than seven bytes is accepted.
- R5: A delimiter with no preamble symbol before it, or any other symbol inside the preamble run, discards the whole frame until rx_dv goes low. No byte of that frame is output.
- R6: out_sof marks the first byte after the delimiter. out_eof marks the last complete byte and is issued once rx_dv has fallen. A one-byte frame carries both flags on the same byte.
- R7: In 10/100 mode, a frame that ends with an unpaired nibble pulses align_err for one cycle, together with the end-of-frame byte. The unpaired nibble is not output. A frame with an even number of nibbles leaves align_err at 0.
- R8: The sampling scheme follows only gig_mode. Byte-per-clock data received with gig_mode=0 is paired from its rising-edge nibbles into misaligned bytes. Nibble-per-clock data received with gig_mode=1 never matches the delimiter and yields no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY receive clock; both edges used in gigabit mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| gig_mode | input | 1 | 1 = double-edge byte capture, 0 = rising-edge nibble pairing |
| rxd | input | 4 | Receive data nibble from the PHY |
| rx_dv | input | 1 | Receive data valid, sampled on the rising edge |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Assembled byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| align_err | output | 1 | One-cycle pulse: frame ended on an unpaired nibble |

## Verification
The bench targets the frame boundaries. It sends one-byte frames, where a design that emits bytes without holding one back would lose the eof flag or split sof and eof across two bytes. It sends frames that end on an odd nibble, where a faulty pairing tracker would either output the unpaired nibble as a byte or stay silent on the error. Shortened preambles, a delimiter with no preamble, and junk inside the preamble run check that the delimiter search neither drops good frames nor lets bad ones through. Both wrong-mode cases and a reset during a frame check that a misconfigured or reset assembler produces visibly wrong or empty output rather than plausible data.

// File: rtl/rgmii_rx_pkg.sv
`timescale 1ns/1ps
package rgmii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;
  // In nibble mode the delimiter is told apart by its upper nibble.
  localparam logic [NIB_W-1:0]  PRE_NIB  = PRE_BYTE[NIB_W-1:0];
  localparam logic [NIB_W-1:0]  SFD_NIB  = SFD_BYTE[BYTE_W-1:NIB_W];

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DROP,
    ST_DATA
  } frm_state_t;

  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] lo,
                                                     input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic is_preamble(input logic [BYTE_W-1:0] sym, input logic gig);
    return gig ? (sym == PRE_BYTE) : (sym[NIB_W-1:0] == PRE_NIB);
  endfunction

  function automatic logic is_sfd(input logic [BYTE_W-1:0] sym, input logic gig);
    return gig ? (sym == SFD_BYTE) : (sym[NIB_W-1:0] == SFD_NIB);
  endfunction
endpackage

// File: rtl/rgmii_rx_capture.sv
`timescale 1ns/1ps
module rgmii_rx_capture
  import rgmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  output logic              sym_vld,
  output logic [BYTE_W-1:0] sym_data
);
  logic [NIB_W-1:0] rise_q;
  logic [NIB_W-1:0] fall_q;
  logic             dv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      rise_q <= rxd;
      dv_q   <= rx_dv;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rxd;
  end

  // Realign both halves into the rising-edge domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_vld  <= 1'b0;
      sym_data <= '0;
    end else begin
      sym_vld  <= dv_q;
      sym_data <= gig_mode ? join_nibbles(rise_q, fall_q) : {{NIB_W{1'b0}}, rise_q};
    end
  end
endmodule

// File: rtl/rgmii_rx_framer.sv
`timescale 1ns/1ps
module rgmii_rx_framer
  import rgmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic              sym_vld,
  input  logic [BYTE_W-1:0] sym_data,
  output logic              frame_start,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_end,
  output logic              odd_end
);
  frm_state_t       state_q, state_d;
  logic             phase_q, phase_d;
  logic [NIB_W-1:0] lo_q, lo_d;

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    lo_d        = lo_q;
    frame_start = 1'b0;
    byte_done   = 1'b0;
    byte_data   = sym_data;
    frame_end   = 1'b0;
    odd_end     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sym_vld) state_d = is_preamble(sym_data, gig_mode) ? ST_PRE : ST_DROP;
      end
      ST_PRE: begin
        if (!sym_vld) begin
          state_d = ST_IDLE;
        end else if (is_sfd(sym_data, gig_mode)) begin
          state_d     = ST_DATA;
          phase_d     = 1'b0;
          frame_start = 1'b1;
        end else if (!is_preamble(sym_data, gig_mode)) begin
          state_d = ST_DROP;
        end
      end
      ST_DROP: begin
        if (!sym_vld) state_d = ST_IDLE;
      end
      ST_DATA: begin
        if (!sym_vld) begin
          state_d   = ST_IDLE;
          frame_end = 1'b1;
          odd_end   = phase_q;
          phase_d   = 1'b0;
        end else if (gig_mode) begin
          byte_done = 1'b1;
        end else if (!phase_q) begin
          lo_d    = sym_data[NIB_W-1:0];
          phase_d = 1'b1;
        end else begin
          byte_done = 1'b1;
          byte_data = join_nibbles(lo_q, sym_data[NIB_W-1:0]);
          phase_d   = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      lo_q    <= lo_d;
    end
  end
endmodule

// File: rtl/rgmii_rx_output.sv
`timescale 1ns/1ps
module rgmii_rx_output
  import rgmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic              odd_end,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              align_err
);
  // One byte is held back so that the last byte can carry end-of-frame.
  logic              pend_vld;
  logic [BYTE_W-1:0] pend_data;
  logic              pend_first;
  logic              first_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_data  <= '0;
      pend_first <= 1'b0;
      first_next <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      align_err  <= 1'b0;
    end else begin
      if (frame_end) begin
        out_valid  <= pend_vld;
        out_data   <= pend_data;
        out_sof    <= pend_vld & pend_first;
        out_eof    <= pend_vld;
        align_err  <= odd_end;
        pend_vld   <= 1'b0;
        pend_first <= 1'b0;
        first_next <= 1'b0;
      end else if (byte_done) begin
        out_valid  <= pend_vld;
        out_data   <= pend_data;
        out_sof    <= pend_vld & pend_first;
        out_eof    <= 1'b0;
        align_err  <= 1'b0;
        pend_vld   <= 1'b1;
        pend_data  <= byte_data;
        pend_first <= first_next;
        first_next <= 1'b0;
      end else begin
        out_valid  <= 1'b0;
        out_sof    <= 1'b0;
        out_eof    <= 1'b0;
        align_err  <= 1'b0;
        if (frame_start) first_next <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgmii_rx_assembler.sv
`timescale 1ns/1ps
module rgmii_rx_assembler
  import rgmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              align_err
);
  logic              sym_vld;
  logic [BYTE_W-1:0] sym_data;
  logic              frame_start;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_data;
  logic              frame_end;
  logic              odd_end;

  rgmii_rx_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .gig_mode (gig_mode),
    .rxd      (rxd),
    .rx_dv    (rx_dv),
    .sym_vld  (sym_vld),
    .sym_data (sym_data)
  );

  rgmii_rx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .gig_mode    (gig_mode),
    .sym_vld     (sym_vld),
    .sym_data    (sym_data),
    .frame_start (frame_start),
    .byte_done   (byte_done),
    .byte_data   (byte_data),
    .frame_end   (frame_end),
    .odd_end     (odd_end)
  );

  rgmii_rx_output u_output (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_done   (byte_done),
    .byte_data   (byte_data),
    .frame_end   (frame_end),
    .odd_end     (odd_end),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .align_err   (align_err)
  );
endmodule

// File: rtl/rgmii_rx_checker.sv
`timescale 1ns/1ps
module rgmii_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic gig_mode,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic align_err,
  input logic byte_done,
  input logic frame_end
);
  logic in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_frame <= 1'b0;
    else if (out_valid) in_frame <= !out_eof;
  end

  // R6: a frame opens only when none is open
  a_r6_sof_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !in_frame);

  // R6 and R1: body bytes appear only inside an opened frame
  a_r6_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> in_frame);

  // R6: flags never stand without a byte
  a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

  // R6: end-of-frame follows the framer's end event
  a_r6_eof_from_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> $past(frame_end));

  // R3: in nibble mode bytes complete at most every other cycle
  a_r3_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig_mode && byte_done) |=> !byte_done);

  // R7: an unpaired nibble can only occur in nibble mode
  a_r7_err_nibble_only: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !gig_mode);
endmodule

bind rgmii_rx_assembler rgmii_rx_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .gig_mode  (gig_mode),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .align_err (align_err),
  .byte_done (byte_done),
  .frame_end (frame_end)
);

// File: tb/tb_rgmii_rx_assembler.sv
`timescale 1ns/1ps
module tb_rgmii_rx_assembler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gig_mode = 1'b1;
  logic [3:0] rxd = 4'h0;
  logic       rx_dv = 1'b0;
  logic       out_valid, out_sof, out_eof, align_err;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int aerr_cnt = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  logic [7:0] wire_q[$];
  logic [3:0] nib_q[$];

  always #2.5 clk = ~clk;

  rgmii_rx_assembler dut (
    .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode), .rxd(rxd), .rx_dv(rx_dv),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .align_err(align_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) got_q.push_back({out_sof, out_eof, out_data});
      if (align_err) aerr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected flags: sof on first, eof on last
  task automatic expect_bytes(input logic [7:0] b[$]);
    exp_q.delete();
    foreach (b[i]) exp_q.push_back({(i == 0), (i == b.size() - 1), b[i]});
  endtask

  task automatic clear_obs();
    got_q.delete();
    aerr_cnt = 0;
  endtask

  task automatic add_pre_gig(input int n);
    for (int i = 0; i < n; i++) wire_q.push_back(8'h55);
    wire_q.push_back(8'hD5);
  endtask

  task automatic add_pre_nib(input int n);
    for (int i = 0; i < n; i++) nib_q.push_back(4'h5);
    nib_q.push_back(4'hD);
  endtask

  task automatic add_byte_nib(input logic [7:0] b);
    nib_q.push_back(b[3:0]);
    nib_q.push_back(b[7:4]);
  endtask

  // double-edge: low nibble before rising edge, high nibble before falling edge
  task automatic drive_ddr();
    foreach (wire_q[i]) begin
      @(negedge clk); #1; rxd = wire_q[i][3:0]; rx_dv = 1'b1;
      @(posedge clk); #1; rxd = wire_q[i][7:4];
    end
    @(negedge clk); #1; rx_dv = 1'b0; rxd = 4'h0;
    wire_q.delete();
  endtask

  // single-edge: one nibble held for a full clock
  task automatic drive_sdr();
    foreach (nib_q[i]) begin
      @(negedge clk); #1; rxd = nib_q[i]; rx_dv = 1'b1;
    end
    @(negedge clk); #1; rx_dv = 1'b0; rxd = 4'h0;
    nib_q.delete();
  endtask

  task automatic compare(input string req, input int exp_aerr);
    repeat (8) @(posedge clk);
    #1;
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size())
        chk(got_q[i] == exp_q[i], {req, " byte/flags"}, got_q[i], exp_q[i]);
    end
    chk(aerr_cnt == exp_aerr, {req, " align_err pulses"}, aerr_cnt, exp_aerr);
    clear_obs();
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(out_sof == 1'b0, "R1 reset out_sof", out_sof, 0);
    chk(out_eof == 1'b0, "R1 reset out_eof", out_eof, 0);
    chk(align_err == 1'b0, "R1 reset align_err", align_err, 0);
  endtask

  task automatic t_gig_basic();
    logic [7:0] p[$] = '{8'hFF, 8'h00, 8'h1D, 8'h7D, 8'hC4, 8'h24};
    gig_mode = 1'b1;
    add_pre_gig(7);
    foreach (p[i]) wire_q.push_back(p[i]);
    expect_bytes(p);
    drive_ddr();
    compare("R2 R4 R6 gig frame", 0);
  endtask

  task automatic t_gig_single();
    logic [7:0] p[$] = '{8'hA7};
    add_pre_gig(7);
    wire_q.push_back(8'hA7);
    expect_bytes(p);
    drive_ddr();
    compare("R6 one-byte frame", 0);
  endtask

  task automatic t_gig_back_to_back();
    logic [7:0] p[$];
    for (int k = 0; k < 2; k++) begin
      p.delete();
      for (int i = 0; i < 5 + k; i++) p.push_back(8'((i * 37 + k * 91 + 3) & 8'hFF));
      add_pre_gig(2 + k);
      foreach (p[i]) wire_q.push_back(p[i]);
      expect_bytes(p);
      drive_ddr();
      compare("R2 R4 back-to-back gig, short preamble", 0);
    end
  endtask

  task automatic t_bad_preamble();
    logic [7:0] none[$];
    expect_bytes(none);
    wire_q.push_back(8'hD5);
    wire_q.push_back(8'h11);
    wire_q.push_back(8'h22);
    drive_ddr();
    compare("R5 delimiter without preamble", 0);
    add_pre_gig(3);
    wire_q.insert(2, 8'h12);
    wire_q.push_back(8'h33);
    wire_q.push_back(8'h44);
    drive_ddr();
    compare("R5 junk inside preamble", 0);
  endtask

  task automatic t_nib_even();
    logic [7:0] p[$] = '{8'h3C, 8'h5A, 8'hE1, 8'h90};
    gig_mode = 1'b0;
    add_pre_nib(15);
    foreach (p[i]) add_byte_nib(p[i]);
    expect_bytes(p);
    drive_sdr();
    compare("R3 R4 R7 nibble even frame", 0);
  endtask

  task automatic t_nib_odd();
    logic [7:0] p[$] = '{8'h81, 8'h2F};
    add_pre_nib(1);
    foreach (p[i]) add_byte_nib(p[i]);
    nib_q.push_back(4'h6);
    expect_bytes(p);
    drive_sdr();
    compare("R7 R4 nibble odd frame, one-nibble preamble", 1);
  endtask

  task automatic t_wrong_mode();
    logic [7:0] p[$] = '{8'hCA};
    logic [7:0] none[$];
    // byte-per-clock data while in nibble mode: rising samples 5..5,D,A,C,B
    gig_mode = 1'b0;
    add_pre_gig(7);
    wire_q.push_back(8'h1D);
    wire_q.push_back(8'h2A);
    wire_q.push_back(8'h3C);
    wire_q.push_back(8'h4B);
    expect_bytes(p);
    drive_ddr();
    compare("R8 double-edge data in nibble mode", 1);
    // nibble-per-clock data while in gigabit mode: bytes 55.., 55, DD
    gig_mode = 1'b1;
    add_pre_nib(15);
    add_byte_nib(8'h42);
    add_byte_nib(8'h17);
    expect_bytes(none);
    drive_sdr();
    compare("R8 single-edge data in gig mode", 0);
  endtask

  task automatic t_reset_mid_frame();
    logic [7:0] none[$];
    gig_mode = 1'b1;
    add_pre_gig(7);
    for (int i = 0; i < 8; i++) wire_q.push_back(8'(8'h60 + i));
    foreach (wire_q[i]) begin
      @(negedge clk); #1; rxd = wire_q[i][3:0]; rx_dv = 1'b1;
      if (i == 10) rst_n = 1'b0;
      if (i == 12) begin rst_n = 1'b1; clear_obs(); end
      @(posedge clk); #1; rxd = wire_q[i][7:4];
    end
    @(negedge clk); #1; rx_dv = 1'b0; rxd = 4'h0;
    wire_q.delete();
    expect_bytes(none);
    compare("R1 reset during frame", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    @(negedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_gig_basic();
    t_gig_single();
    t_gig_back_to_back();
    t_bad_preamble();
    t_nib_even();
    t_nib_odd();
    t_wrong_mode();
    t_reset_mid_frame();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule